// File: doc/BRIEF.md
# Converter Wake-Up Sequencer with Coupling-Charge Output Gate

This block brings a record-path converter out of sleep. After a wake request it turns on the supply regulator, the voltage reference, the clock synthesiser, the modulator and the digital filter path. Each enable stays on once raised. The regulator, reference, modulator and digital phases each last a number of time-base ticks held in a configuration input. The clock-synthesiser phase ends as soon as the lock indication is seen. If lock does not arrive within a programmable tick limit, the block enters a fault state.

Once the digital path is up, the serial output stays muted for one more interval. This interval lets the external input coupling capacitors charge. Its length comes from a small select code, which is captured at the wake request. When the interval ends, the data-valid (unmute) output rises. Any soft volume ramp is started by logic downstream of that signal, so it never delays the gate.

The time base is either an external tick pulse or an internal divider of the clock. A sleep request at any point drops every output on the next edge.

Top module: `pwrup_seq`

## Requirements
- R1: In a wake sequence the enables rise in this strict order: `en_reg`, `en_ref`, `en_pll`, `en_mod`, `en_dig`. Each stays high until the sequence ends, and all are low in sleep.
- R2: The regulator, reference, modulator and digital phases each last exactly max(L,1) ticks, where L is `len_reg`, `len_ref`, `len_mod` or `len_dig`. With the tick held high, that is max(L,1) clock cycles.
- R3: The clock-synthesiser phase ends on the first cycle in which `pll_lock` is sampled high. `en_mod` rises on the following edge.
- R4: If lock has not been seen by the `lock_limit`-th tick of the synthesiser phase, the block enters a fault state. In the fault state `lock_err` is high and all enables and `data_valid` are low, until a sleep request. Lock arriving in the same cycle as the limit tick wins, and no fault is raised.
- R5: After the digital phase, the output stays muted for 5 + 20*code ticks (code 0..3 gives 5, 25, 45, 65). `data_valid` then rises and holds.
- R6: The 2-bit `qchg_sel` code is captured on the wake edge. Changes to it during the sequence have no effect on the charge interval.
- R7: A sleep request in any non-sleep state returns the block to sleep on the next edge, with all outputs low. It takes priority over phase completion and over a lock arriving in the same cycle.
- R8: `busy` is high exactly during the power-up phases (regulator through charge). It is low in sleep, in the active state and in the fault state.
- R9: A wake request is ignored outside sleep. A wake and a sleep request in the same cycle while in sleep leave the block asleep.
- R10: With `base_sel`=1 the tick comes from an internal divider of CYC_DIV cycles, restarted at wake. The regulator phase then lasts L*CYC_DIV cycles.
- R11: Synchronous active-high reset puts the block in sleep with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Request to leave sleep |
| sleep_req | input | 1 | Request to return to sleep (abort) |
| tick_in | input | 1 | External time-base pulse |
| base_sel | input | 1 | 1 selects the internal cycle divider as the time base |
| qchg_sel | input | QW | Coupling-charge duration code |
| pll_lock | input | 1 | Clock synthesiser lock indication |
| len_reg | input | TW | Regulator phase length in ticks |
| len_ref | input | TW | Reference phase length in ticks |
| len_mod | input | TW | Modulator phase length in ticks |
| len_dig | input | TW | Digital path phase length in ticks |
| lock_limit | input | TW | Lock wait limit in ticks |
| en_reg | output | 1 | Regulator enable |
| en_ref | output | 1 | Reference enable |
| en_pll | output | 1 | Clock synthesiser enable |
| en_mod | output | 1 | Modulator enable |
| en_dig | output | 1 | Digital path enable |
| data_valid | output | 1 | Output data unmuted |
| busy | output | 1 | Power-up in progress |
| lock_err | output | 1 | Lock timeout fault |

## Verification
Two pairs of events can land in the same cycle. The first is lock arrival with expiry of the lock limit. The bench raises `pll_lock` in exactly the cycle of the limit tick and expects the modulator phase, not a fault. The second is a sleep request with a lock arrival (or phase completion). The bench drives both in one cycle and expects sleep with every enable low and the modulator enable never raised. A sweep over all charge codes and several regulator lengths checks every phase length arithmetically.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_SLEEP  = 4'd0,
        ST_REG    = 4'd1,
        ST_REF    = 4'd2,
        ST_PLL    = 4'd3,
        ST_MOD    = 4'd4,
        ST_DIG    = 4'd5,
        ST_CHG    = 4'd6,
        ST_ACTIVE = 4'd7,
        ST_FAULT  = 4'd8
    } seq_state_e;

    typedef struct packed {
        logic reg_on;
        logic ref_on;
        logic pll_on;
        logic mod_on;
        logic dig_on;
    } en_vec_t;

    function automatic en_vec_t decode_en(seq_state_e s);
        en_vec_t e;
        e.reg_on = (s inside {ST_REG, ST_REF, ST_PLL, ST_MOD, ST_DIG, ST_CHG, ST_ACTIVE});
        e.ref_on = (s inside {ST_REF, ST_PLL, ST_MOD, ST_DIG, ST_CHG, ST_ACTIVE});
        e.pll_on = (s inside {ST_PLL, ST_MOD, ST_DIG, ST_CHG, ST_ACTIVE});
        e.mod_on = (s inside {ST_MOD, ST_DIG, ST_CHG, ST_ACTIVE});
        e.dig_on = (s inside {ST_DIG, ST_CHG, ST_ACTIVE});
        return e;
    endfunction

    function automatic logic is_powering(seq_state_e s);
        return (s inside {ST_REG, ST_REF, ST_PLL, ST_MOD, ST_DIG, ST_CHG});
    endfunction

    function automatic int unsigned chg_len(int unsigned code, int unsigned base,
                                            int unsigned step);
        return base + code * step;
    endfunction

endpackage

// File: rtl/pws_timebase.sv
module pws_timebase #(
    parameter int CYC_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic base_sel,
    input  logic tick_in,
    output logic tick
);
    logic div_tick;

    generate
        if (CYC_DIV <= 1) begin : g_nodiv
            assign div_tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CYC_DIV);
            localparam logic [DW-1:0] LAST = DW'(CYC_DIV - 1);
            logic [DW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign div_tick = !clr && (cnt_q == LAST);

            p_div_gap_r10: assert property (@(posedge clk) disable iff (rst)
                (div_tick && !clr) |=> !div_tick);
        end
    endgenerate

    assign tick = base_sel ? div_tick : tick_in;

endmodule

// File: rtl/pws_phase_timer.sv
module pws_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    input  logic          tick,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // phase ends on the tick that brings the count to zero (length 0 acts as 1)
    assign done = tick && (cnt_q <= TW'(1));

    p_load_len_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(len)));

endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
    import pwrseq_pkg::*;
#(
    parameter int TW      = 8,
    parameter int QW      = 2,
    parameter int QC_BASE = 5,
    parameter int QC_STEP = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake_req,
    input  logic          sleep_req,
    input  logic          pll_lock,
    input  logic          phase_done,
    input  logic [QW-1:0] qchg_sel,
    input  logic [TW-1:0] len_reg,
    input  logic [TW-1:0] len_ref,
    input  logic [TW-1:0] len_mod,
    input  logic [TW-1:0] len_dig,
    input  logic [TW-1:0] lock_limit,
    output seq_state_e    state,
    output logic          load,
    output logic [TW-1:0] load_len
);
    seq_state_e    state_q, nxt;
    logic [QW-1:0] code_q;
    logic [TW-1:0] chg_ticks;
    logic          start;

    assign chg_ticks = TW'(chg_len(int'(code_q), QC_BASE, QC_STEP));
    assign start     = (state_q == ST_SLEEP) && wake_req && !sleep_req;

    always_comb begin
        nxt      = state_q;
        load     = 1'b0;
        load_len = '0;
        if (state_q != ST_SLEEP && sleep_req) begin
            nxt = ST_SLEEP;
        end else begin
            case (state_q)
                ST_SLEEP: if (start) begin
                    nxt = ST_REG; load = 1'b1; load_len = len_reg;
                end
                ST_REG: if (phase_done) begin
                    nxt = ST_REF; load = 1'b1; load_len = len_ref;
                end
                ST_REF: if (phase_done) begin
                    nxt = ST_PLL; load = 1'b1; load_len = lock_limit;
                end
                ST_PLL: if (pll_lock) begin
                    nxt = ST_MOD; load = 1'b1; load_len = len_mod;
                end else if (phase_done) begin
                    nxt = ST_FAULT;
                end
                ST_MOD: if (phase_done) begin
                    nxt = ST_DIG; load = 1'b1; load_len = len_dig;
                end
                ST_DIG: if (phase_done) begin
                    nxt = ST_CHG; load = 1'b1; load_len = chg_ticks;
                end
                ST_CHG: if (phase_done) begin
                    nxt = ST_ACTIVE;
                end
                ST_ACTIVE: nxt = ST_ACTIVE;
                ST_FAULT:  nxt = ST_FAULT;
                default:   nxt = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SLEEP;
            code_q  <= '0;
        end else begin
            state_q <= nxt;
            if (start) begin
                code_q <= qchg_sel;
            end
        end
    end

    assign state = state_q;

    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && state_q != ST_SLEEP) |=> (state_q == ST_SLEEP));

    p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $stable(code_q));

    p_wake_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !sleep_req && state_q == ST_ACTIVE) |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int TW      = 8,
    parameter int QW      = 2,
    parameter int QC_BASE = 5,
    parameter int QC_STEP = 20,
    parameter int CYC_DIV = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake_req,
    input  logic          sleep_req,
    input  logic          tick_in,
    input  logic          base_sel,
    input  logic [QW-1:0] qchg_sel,
    input  logic          pll_lock,
    input  logic [TW-1:0] len_reg,
    input  logic [TW-1:0] len_ref,
    input  logic [TW-1:0] len_mod,
    input  logic [TW-1:0] len_dig,
    input  logic [TW-1:0] lock_limit,
    output logic          en_reg,
    output logic          en_ref,
    output logic          en_pll,
    output logic          en_mod,
    output logic          en_dig,
    output logic          data_valid,
    output logic          busy,
    output logic          lock_err
);
    seq_state_e    state;
    logic          tick, load, phase_done;
    logic [TW-1:0] load_len;
    en_vec_t       ens;

    pws_timebase #(.CYC_DIV(CYC_DIV)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .clr      (state == ST_SLEEP),
        .base_sel (base_sel),
        .tick_in  (tick_in),
        .tick     (tick)
    );

    pws_phase_timer #(.TW(TW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (load_len),
        .tick (tick),
        .done (phase_done)
    );

    pws_fsm #(.TW(TW), .QW(QW), .QC_BASE(QC_BASE), .QC_STEP(QC_STEP)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wake_req   (wake_req),
        .sleep_req  (sleep_req),
        .pll_lock   (pll_lock),
        .phase_done (phase_done),
        .qchg_sel   (qchg_sel),
        .len_reg    (len_reg),
        .len_ref    (len_ref),
        .len_mod    (len_mod),
        .len_dig    (len_dig),
        .lock_limit (lock_limit),
        .state      (state),
        .load       (load),
        .load_len   (load_len)
    );

    assign ens        = decode_en(state);
    assign en_reg     = ens.reg_on;
    assign en_ref     = ens.ref_on;
    assign en_pll     = ens.pll_on;
    assign en_mod     = ens.mod_on;
    assign en_dig     = ens.dig_on;
    assign data_valid = (state == ST_ACTIVE);
    assign busy       = is_powering(state);
    assign lock_err   = (state == ST_FAULT);

    p_order_ref_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(en_ref) |-> $past(en_reg));
    p_order_pll_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(en_pll) |-> $past(en_ref));
    p_order_mod_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(en_mod) |-> ($past(en_pll) && $past(pll_lock)));
    p_order_dig_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(en_dig) |-> $past(en_mod));
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> ($past(en_dig) && $past(phase_done) && !$past(sleep_req)));
    p_fault_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_err) |-> ($past(en_pll) && !$past(pll_lock) && $past(phase_done)));
    p_busy_mute_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!data_valid && !lock_err));

endmodule

// File: tb/sim_pwrup_seq.sv
module sim_pwrup_seq;
    localparam int TW = 8, QW = 2, QB = 5, QS = 20, DIV = 4;

    logic clk = 1'b0, rst = 1'b1, wake = 1'b0, slp = 1'b0, tick = 1'b1;
    logic bsel = 1'b0, lock = 1'b1;
    logic [QW-1:0] qsel = '0;
    logic [TW-1:0] lreg = 8'd1, lref = 8'd2, lmod = 8'd3, ldig = 8'd2, llim = 8'd6;
    logic en_reg, en_ref, en_pll, en_mod, en_dig, dv, busy, lerr;

    int errs = 0, checks = 0;
    int t_reg, t_ref, t_pll, t_mod, t_dig, t_dv, t_err;
    bit busy_bad;

    always #5 clk = ~clk;

    pwrup_seq #(.TW(TW), .QW(QW), .QC_BASE(QB), .QC_STEP(QS), .CYC_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .wake_req(wake), .sleep_req(slp), .tick_in(tick),
        .base_sel(bsel), .qchg_sel(qsel), .pll_lock(lock), .len_reg(lreg),
        .len_ref(lref), .len_mod(lmod), .len_dig(ldig), .lock_limit(llim),
        .en_reg(en_reg), .en_ref(en_ref), .en_pll(en_pll), .en_mod(en_mod),
        .en_dig(en_dig), .data_valid(dv), .busy(busy), .lock_err(lerr));

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int all_out();
        return {en_reg, en_ref, en_pll, en_mod, en_dig, dv, busy, lerr};
    endfunction

    task automatic run(input int limit, input int lock_at, input int sleep_at, input int new_code);
        int n = 0;
        int sl_n = -1;
        t_reg = -1; t_ref = -1; t_pll = -1; t_mod = -1; t_dig = -1; t_dv = -1; t_err = -1;
        busy_bad = 1'b0;
        @(negedge clk) wake = 1'b1;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (n == 1) wake = 1'b0;
            if (sl_n >= 0 && n == sl_n + 1) slp = 1'b0;
            if (en_reg && t_reg < 0) t_reg = n;
            if (en_ref && t_ref < 0) t_ref = n;
            if (en_pll && t_pll < 0) t_pll = n;
            if (en_mod && t_mod < 0) t_mod = n;
            if (en_dig && t_dig < 0) t_dig = n;
            if (dv && t_dv < 0) t_dv = n;
            if (lerr && t_err < 0) t_err = n;
            if (busy && (dv || lerr)) busy_bad = 1'b1;
            if (en_reg && !dv && !busy) busy_bad = 1'b1;
            if (n == 2 && new_code >= 0) qsel = QW'(new_code);
            if (t_pll >= 0 && lock_at >= 0 && n == t_pll + lock_at) lock = 1'b1;
            if (t_pll >= 0 && sleep_at >= 0 && n == t_pll + sleep_at) begin
                slp = 1'b1;
                sl_n = n;
            end
            if (dv || lerr) break;
        end
        slp = 1'b0;
    endtask

    task automatic go_sleep(input string tag);
        @(negedge clk) slp = 1'b1;
        @(negedge clk) slp = 1'b0;
        chk_eq(tag, all_out(), 0);
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_eq("R11 outputs low in reset", all_out(), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R11 outputs low after reset", all_out(), 0);

        // sweep: every charge code against several regulator lengths
        for (int code = 0; code < 4; code++) begin
            for (int li = 0; li < 3; li++) begin
                int lr;
                lr = (li == 0) ? 0 : ((li == 1) ? 1 : 4);
                lreg = TW'(lr);
                qsel = QW'(code);
                lock = 1'b1;
                run(300, -1, -1, -1);
                chk_eq("R1 enable order", int'(t_reg < t_ref && t_ref < t_pll && t_pll < t_mod
                       && t_mod < t_dig && t_dig < t_dv), 1);
                chk_eq("R2 regulator phase", t_ref - t_reg, (lr == 0) ? 1 : lr);
                chk_eq("R2 reference phase", t_pll - t_ref, int'(lref));
                chk_eq("R3 lock phase", t_mod - t_pll, 1);
                chk_eq("R2 modulator phase", t_dig - t_mod, int'(lmod));
                chk_eq("R5 digital plus charge", t_dv - t_dig, int'(ldig) + QB + code * QS);
                chk_eq("R8 busy profile", int'(busy_bad), 0);
                chk_eq("R8 busy low when active", int'(busy), 0);
                go_sleep("R1 all low after sleep");
            end
        end
        lreg = 8'd1;

        // R6: code changed after wake has no effect
        qsel = 2'd1;
        run(300, -1, -1, 3);
        chk_eq("R6 latched charge code", t_dv - t_dig, int'(ldig) + QB + QS);

        // R9: wake while active ignored
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
        chk_eq("R9 active unchanged after wake", all_out(), 8'b11111100);
        repeat (2) @(negedge clk);
        chk_eq("R9 active still unchanged", all_out(), 8'b11111100);
        go_sleep("R7 sleep from active");
        qsel = 2'd0;

        // R4: lock timeout
        lock = 1'b0;
        llim = 8'd6;
        run(100, -1, -1, -1);
        chk_eq("R4 timeout length", t_err - t_pll, 6);
        chk_eq("R4 no modulator", t_mod, -1);
        chk_eq("R4 fault outputs", all_out(), 8'b00000001);
        repeat (4) @(negedge clk);
        chk_eq("R4 fault held", all_out(), 8'b00000001);
        go_sleep("R4 fault cleared by sleep");

        // R4: lock in the same cycle as the limit tick
        lock = 1'b0;
        llim = 8'd4;
        run(200, 3, -1, -1);
        chk_eq("R4 lock at limit wins", t_mod - t_pll, 4);
        chk_eq("R4 no fault on coincident lock", t_err, -1);
        chk_eq("R4 data released", int'(dv), 1);
        go_sleep("R7 sleep after coincidence");

        // R7: sleep in the same cycle as lock
        lock = 1'b0;
        llim = 8'd20;
        run(40, 2, 2, -1);
        chk_eq("R7 sleep beats lock", t_mod, -1);
        chk_eq("R7 all low after abort", all_out(), 0);
        chk_eq("R7 no fault after abort", t_err, -1);
        lock = 1'b1;

        // R7: abort during charge interval
        run(150, -1, 8, -1);
        chk_eq("R7 no data after charge abort", t_dv, -1);
        chk_eq("R7 all low after charge abort", all_out(), 0);

        // R9: wake and sleep together in sleep
        @(negedge clk) begin wake = 1'b1; slp = 1'b1; end
        @(negedge clk) begin wake = 1'b0; slp = 1'b0; end
        chk_eq("R9 wake with sleep stays asleep", all_out(), 0);

        // R10: internal divider time base
        bsel = 1'b1;
        tick = 1'b0;
        lreg = 8'd3;
        run(300, -1, -1, -1);
        chk_eq("R10 divided regulator phase", t_ref - t_reg, 3 * DIV);
        chk_eq("R10 sequence completes", int'(dv), 1);
        go_sleep("R10 sleep");
        bsel = 1'b0;
        tick = 1'b1;
        lreg = 8'd1;

        // R11: reset mid sequence
        run(4, -1, -1, -1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk_eq("R11 reset aborts sequence", all_out(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule